// File: doc/BRIEF.md
# Debug Address Watchpoint Match Unit

This block watches a processor's memory traffic on behalf of a debugger. It holds four address slots. A single 32-bit control word gives each slot a pair of enable bits and a packed access-type/length field. Every cycle that the bus monitor reports an access, each enabled slot compares the access against its watched region. The access may be an instruction fetch, a data read or a data write. A match sets that slot's sticky status bit, and the trap output pulses when a slot whose status was clear begins to hit.

Software loads the slot addresses, the control word and status clears through one register write port, selected by a small index. A task-switch pulse drops every local enable and leaves the global enables in place, so per-task watchpoints disappear on a context change and system-wide ones remain. A data slot watches a naturally aligned region of 1, 2, 4 or 8 bytes. Any access whose byte range overlaps that region matches. An instruction slot matches only a fetch at exactly its address.

Top module: `dbgw_unit`

## Requirements
- R1: After reset the control word, all status bits and the trap output are 0.
- R2: Slot i uses control bit 2*i as its local enable and bit 2*i+1 as its global enable. Its type/length field is control bits [16+4*i+3:16+4*i]. A slot with both enables 0 never matches.
- R3: The type code in field bits [1:0] works as follows. 00 matches fetches, 01 matches data writes only, and 11 matches data reads and data writes. Code 10 never matches. On acc_kind, 00 is fetch, 01 is write, 10 is read and 11 is idle.
- R4: The length code in field bits [3:2] works as follows. 00 is 1 byte, 01 is 2 bytes, 11 is 4 bytes and 10 is 8 bytes. The 8-byte code is honoured only when ALLOW_LEN8 is 1. A data slot matches when the access range [acc_addr, acc_addr + 2^acc_size) overlaps [slot_addr with its low bits cleared to the length, + length).
- R5: A fetch slot matches only when the fetch address equals the slot address and its length code is 00. It never matches a data access.
- R6: A task_switch pulse clears every local enable bit at the next edge and leaves the global enable bits unchanged.
- R7: A hit sets the slot's status bit, which stays set until a status write (reg_sel 5) carries a 1 in that bit. A 0 leaves the bit alone. A hit in the same cycle as its clear leaves the bit set.
- R8: Control bits 15..10 always read back 0. Bits 9 and 8 are stored as written and do not change matching.
- R9: trap is high for one cycle, in the cycle after an access hits a slot whose status bit was clear. A hit on a slot already flagged raises no trap.
- R10: Several slots hitting on the same access set all of their status bits together. Slot addresses are written with reg_sel 0..3 and the control word with reg_sel 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus monitor reports an access this cycle |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 write, 10 read, 11 idle |
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_size | input | 2 | log2 of the access size in bytes |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0..3 slot address, 4 control word, 5 status clear |
| reg_wdata | input | 32 | Register write data |
| task_switch | input | 1 | Context-switch pulse, clears local enables |
| ctrl_word | output | 32 | Current control word |
| hit_status | output | NUM_SLOTS | Sticky per-slot hit bits |
| trap | output | 1 | One-cycle debug trap pulse |

## Verification
Every cycle, the embedded assertions check the following. The reserved control bits stay 0. Local enables are gone after a task switch while global enables persist. Vacant slots and slots with the I/O code stay silent. Status bits are lost only through a write-one clear, and every trap is backed by a set status bit. The region arithmetic needs the bench's scenarios: the non-monotonic length code, aligned bases with accesses straddling either edge, and the fetch-only exact compare. The same holds for the same-cycle hit/clear collision, the one-cycle trap timing and the suppressed trap on an already flagged slot.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_IDLE  = 2'b11
  } acc_kind_e;

  localparam logic [1:0] RW_FETCH = 2'b00;
  localparam logic [1:0] RW_WR    = 2'b01;
  localparam logic [1:0] RW_IO    = 2'b10;
  localparam logic [1:0] RW_RDWR  = 2'b11;

  localparam logic [1:0] LEN_1 = 2'b00;
  localparam logic [1:0] LEN_2 = 2'b01;
  localparam logic [1:0] LEN_8 = 2'b10;
  localparam logic [1:0] LEN_4 = 2'b11;

  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  localparam int FIELD_BASE = 16;
  localparam int FIELD_W    = 4;
  localparam int RSV_LO     = 10;
  localparam int RSV_N      = 6;

  // Length code to log2 of the region size in bytes.
  function automatic logic [1:0] len_log2(input logic [1:0] code);
    case (code)
      LEN_1:   len_log2 = 2'd0;
      LEN_2:   len_log2 = 2'd1;
      LEN_4:   len_log2 = 2'd2;
      default: len_log2 = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/dbgw_slot.sv
module dbgw_slot
  import dbgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit ALLOW_LEN8 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [1:0]        en,
  input  logic [3:0]        fld,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic              match
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        rw, lc, lg;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   reg_end, acc_end;
  logic              overlap, len_ok, kind_ok;

  always_comb begin
    addr_d = addr_q;
    if (addr_we) addr_d = addr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_we) addr_q <= addr_d;
  end

  always_comb begin
    rw      = fld[1:0];
    lc      = fld[3:2];
    lg      = len_log2(lc);
    len_ok  = (lc != LEN_8) || ALLOW_LEN8;
    base    = addr_q & ({ADDR_W{1'b1}} << lg);
    reg_end = {1'b0, base} + ((ADDR_W+1)'(1) << lg);
    acc_end = {1'b0, acc_addr} + ((ADDR_W+1)'(1) << acc_size);
    overlap = ({1'b0, acc_addr} < reg_end) && ({1'b0, base} < acc_end);
    case (rw)
      RW_FETCH: kind_ok = (acc_kind == ACC_FETCH) && (lc == LEN_1) && (acc_addr == addr_q);
      RW_WR:    kind_ok = (acc_kind == ACC_WRITE) && overlap;
      RW_RDWR:  kind_ok = ((acc_kind == ACC_WRITE) || (acc_kind == ACC_READ)) && overlap;
      default:  kind_ok = 1'b0;
    endcase
    match = acc_valid && (|en) && len_ok && kind_ok;
  end

  // R2: a vacant slot stays silent
  p_vacant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b00) |-> !match);
  // R3: the I/O type code never matches
  p_io_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fld[1:0] == RW_IO) |-> !match);
  // R5: a fetch slot ignores data accesses
  p_fetch_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fld[1:0] == RW_FETCH && acc_kind != ACC_FETCH) |-> !match);
endmodule

// File: rtl/dbgw_ctrl.sv
module dbgw_ctrl
  import dbgw_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        task_switch,
  output logic [31:0] ctrl_q
);
  function automatic logic [31:0] enable_mask(input int off);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++) m[2*i+off] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] LOCAL_MASK  = enable_mask(0);
  localparam logic [31:0] GLOBAL_MASK = enable_mask(1);
  localparam logic [31:0] KEEP_MASK   = ~(32'((1 << RSV_N) - 1) << RSV_LO);

  logic [31:0] ctrl_d;
  logic        ctrl_en;

  always_comb begin
    ctrl_en = we || task_switch;
    ctrl_d  = we ? (wdata & KEEP_MASK) : ctrl_q;
    if (task_switch) ctrl_d = ctrl_d & ~LOCAL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // R8: reserved bits read back zero
  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[RSV_LO +: RSV_N] == '0);
  // R6: local enables gone after a task switch
  p_local_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> ((ctrl_q & LOCAL_MASK) == '0));
  // R6: global enables survive a task switch
  p_global_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !we) |=> ((ctrl_q & GLOBAL_MASK) == $past(ctrl_q & GLOBAL_MASK)));
endmodule

// File: rtl/dbgw_status.sv
module dbgw_status #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] match,
  input  logic                 clr_we,
  input  logic [NUM_SLOTS-1:0] clr_mask,
  output logic [NUM_SLOTS-1:0] status_q,
  output logic                 trap_q
);
  logic [NUM_SLOTS-1:0] clr_eff, status_d;
  logic                 status_en, trap_d;

  always_comb begin
    clr_eff   = clr_we ? clr_mask : '0;
    status_en = clr_we || (|match);
    status_d  = (status_q & ~clr_eff) | match;
    trap_d    = |(match & ~status_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  // R7: a set bit is lost only through a write-one clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_eff)) & ~status_q) == '0));
  // R10: every matching slot is flagged
  p_all_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|match) |=> ((status_q & $past(match)) == $past(match)));
  // R9: a trap always has a flagged slot behind it
  p_trap_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (status_q != '0));
endmodule

// File: rtl/dbgw_unit.sv
module dbgw_unit
  import dbgw_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int ADDR_W     = 32,
  parameter bit ALLOW_LEN8 = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic [1:0]           acc_kind,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [1:0]           acc_size,
  input  logic                 reg_we,
  input  logic [2:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  input  logic                 task_switch,
  output logic [31:0]          ctrl_word,
  output logic [NUM_SLOTS-1:0] hit_status,
  output logic                 trap
);
  logic [NUM_SLOTS-1:0] slot_match;
  logic                 ctrl_we, stat_we;

  assign ctrl_we = reg_we && (reg_sel == SEL_CTRL);
  assign stat_we = reg_we && (reg_sel == SEL_STAT);

  dbgw_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (ctrl_we),
    .wdata       (reg_wdata),
    .task_switch (task_switch),
    .ctrl_q      (ctrl_word)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    dbgw_slot #(.ADDR_W(ADDR_W), .ALLOW_LEN8(ALLOW_LEN8)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_we    (reg_we && (reg_sel == 3'(i))),
      .addr_wdata (reg_wdata[ADDR_W-1:0]),
      .en         (ctrl_word[2*i +: 2]),
      .fld        (ctrl_word[FIELD_BASE + FIELD_W*i +: FIELD_W]),
      .acc_valid  (acc_valid),
      .acc_kind   (acc_kind),
      .acc_addr   (acc_addr),
      .acc_size   (acc_size),
      .match      (slot_match[i])
    );
  end

  dbgw_status #(.NUM_SLOTS(NUM_SLOTS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (slot_match),
    .clr_we   (stat_we),
    .clr_mask (reg_wdata[NUM_SLOTS-1:0]),
    .status_q (hit_status),
    .trap_q   (trap)
  );
endmodule

// File: tb/dbgw_unit_tb.sv
module dbgw_unit_tb;
  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] a0;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [3:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  // kind: 0 fetch, 1 write, 2 read
  localparam vec_t VEC [NV] = '{
    '{32'h00010001, 32'h1000, 2'd1, 32'h1000, 2'd0, 4'h1, 4'd3}, // R3 write slot, write
    '{32'h00010001, 32'h1000, 2'd2, 32'h1000, 2'd0, 4'h0, 4'd3}, // R3 write slot, read
    '{32'h00030001, 32'h1000, 2'd2, 32'h1000, 2'd0, 4'h1, 4'd3}, // R3 rd/wr slot, read
    '{32'h00020001, 32'h1000, 2'd1, 32'h1000, 2'd0, 4'h0, 4'd3}, // R3 I/O code
    '{32'h000F0001, 32'h1002, 2'd2, 32'h1003, 2'd0, 4'h1, 4'd4}, // R4 4B inside
    '{32'h000F0001, 32'h1002, 2'd2, 32'h1004, 2'd0, 4'h0, 4'd4}, // R4 4B past end
    '{32'h000F0001, 32'h1002, 2'd1, 32'h0FFE, 2'd2, 4'h1, 4'd4}, // R4 straddle low edge
    '{32'h000F0001, 32'h1002, 2'd1, 32'h0FFC, 2'd2, 4'h0, 4'd4}, // R4 just below
    '{32'h000F0001, 32'h1002, 2'd2, 32'h0FF8, 2'd3, 4'h0, 4'd4}, // R4 8B access below
    '{32'h000F0001, 32'h1002, 2'd2, 32'h0FFC, 2'd3, 4'h1, 4'd4}, // R4 8B access overlaps
    '{32'h00070001, 32'h2001, 2'd2, 32'h2000, 2'd0, 4'h1, 4'd4}, // R4 2B aligned base
    '{32'h00070001, 32'h2001, 2'd2, 32'h2002, 2'd0, 4'h0, 4'd4}, // R4 2B past end
    '{32'h000B0001, 32'h3005, 2'd2, 32'h3007, 2'd0, 4'h1, 4'd4}, // R4 8B region
    '{32'h000B0001, 32'h3005, 2'd2, 32'h3008, 2'd0, 4'h0, 4'd4}, // R4 8B past end
    '{32'h00000002, 32'h4000, 2'd0, 32'h4000, 2'd0, 4'h1, 4'd5}, // R5 exact fetch
    '{32'h00000002, 32'h4000, 2'd0, 32'h4001, 2'd0, 4'h0, 4'd5}, // R5 other fetch
    '{32'h00000002, 32'h4000, 2'd1, 32'h4000, 2'd0, 4'h0, 4'd5}, // R5 data on fetch slot
    '{32'h00040002, 32'h4000, 2'd0, 32'h4000, 2'd0, 4'h0, 4'd5}, // R5 fetch with len!=00
    '{32'h000F0000, 32'h1000, 2'd2, 32'h1000, 2'd0, 4'h0, 4'd2}, // R2 vacant slot
    '{32'h000F0301, 32'h1000, 2'd2, 32'h1004, 2'd0, 4'h0, 4'd8}, // R8 exact flags, miss
    '{32'h000F0301, 32'h1000, 2'd2, 32'h1002, 2'd0, 4'h1, 4'd8}  // R8 exact flags, hit
  };

  logic        clk, rst_n;
  logic        acc_valid;
  logic [1:0]  acc_kind;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        task_switch;
  logic [31:0] ctrl_word;
  logic [3:0]  hit_status;
  logic        trap;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  dbgw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_size(acc_size), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .task_switch(task_switch), .ctrl_word(ctrl_word),
    .hit_status(hit_status), .trap(trap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic access(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = s;
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'd3;
  endtask

  task automatic pulse_ts();
    @(negedge clk);
    task_switch = 1'b1;
    @(negedge clk);
    task_switch = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_kind = 2'd3; acc_addr = '0; acc_size = '0;
    reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; task_switch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", ctrl_word, 32'h0);
    check("R1 status", {28'h0, hit_status}, 32'h0);
    check("R1 trap", {31'h0, trap}, 32'h0);

    // vector table, slot 0
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, VEC[v].a0);
      wr(3'd4, VEC[v].ctrl);
      wr(3'd5, 32'hF);
      access(VEC[v].kind, VEC[v].addr, VEC[v].size);
      check($sformatf("R%0d vec%0d status", VEC[v].req, v), {28'h0, hit_status}, {28'h0, VEC[v].exp});
      check($sformatf("R%0d vec%0d trap", VEC[v].req, v), {31'h0, trap}, {31'h0, |VEC[v].exp});
    end

    // R2 slot 1 field position
    wr(3'd5, 32'hF);
    wr(3'd1, 32'h5000);
    wr(3'd4, 32'h00300004);
    access(2'd2, 32'h5000, 2'd0);
    check("R2 slot1 layout", {28'h0, hit_status}, 32'h2);

    // R10 two slots hit together
    wr(3'd5, 32'hF);
    wr(3'd2, 32'h6000);
    wr(3'd3, 32'h6000);
    wr(3'd4, 32'h330000A0);
    access(2'd1, 32'h6000, 2'd0);
    check("R10 multi status", {28'h0, hit_status}, 32'hC);
    check("R10 multi trap", {31'h0, trap}, 32'h1);

    // R8 reserved bits
    wr(3'd4, 32'hFFFFFFFF);
    check("R8 readback", ctrl_word, 32'hFFFF03FF);
    // R6 task switch clears local only
    pulse_ts();
    check("R6 ctrl after switch", ctrl_word, 32'hFFFF03AA);
    wr(3'd5, 32'hF);
    wr(3'd0, 32'h1000);
    wr(3'd4, 32'h000F0001);
    pulse_ts();
    access(2'd2, 32'h1000, 2'd0);
    check("R6 local dropped", {28'h0, hit_status}, 32'h0);
    wr(3'd4, 32'h000F0002);
    pulse_ts();
    access(2'd2, 32'h1000, 2'd0);
    check("R6 global kept", {28'h0, hit_status}, 32'h1);

    // R9 trap lasts one cycle
    check("R9 trap high", {31'h0, trap}, 32'h1);
    @(negedge clk);
    check("R9 trap one cycle", {31'h0, trap}, 32'h0);
    access(2'd2, 32'h1000, 2'd0);
    check("R9 no trap when flagged", {31'h0, trap}, 32'h0);
    check("R9 still flagged", {28'h0, hit_status}, 32'h1);

    // R7 sticky and write-one clear
    wr(3'd5, 32'h0);
    check("R7 zero write keeps", {28'h0, hit_status}, 32'h1);
    wr(3'd5, 32'h2);
    check("R7 other bit keeps", {28'h0, hit_status}, 32'h1);
    wr(3'd5, 32'h1);
    check("R7 clear", {28'h0, hit_status}, 32'h0);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = 2'd2; acc_addr = 32'h1000; acc_size = 2'd0;
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h1;
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'd3; reg_we = 1'b0;
    check("R7 hit beats clear", {28'h0, hit_status}, 32'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule